// File: doc/BRIEF.md
# Register-Mapped Factorial Engine

This block computes the factorial of a value that software writes into an operand register. It sits behind a plain single-cycle register port: a write strobe with address and data, and a read data bus that always shows the word selected by the current address. Writing the operand starts a loop that does one multiply per clock. When the loop ends, the result takes the operand's place in the same register.

A status word shows a busy flag and an interrupt-enable flag. Software sets or clears the enable flag; the engine alone drives busy. When a computation finishes with the enable flag set, the engine raises a one-cycle interrupt request that carries a fixed cause code. A separate liveness register stores the bitwise complement of whatever is written to it. Software reads it back to confirm that the register path is alive.

Top module: `fact_engine`

## Requirements
- R1: Word address 0 is the liveness register, 1 is the operand/result register and 2 is the status register. Address 3 reads as zero. In the status word, bit 0 is busy, bit 7 is interrupt enable, and every other bit reads zero.
- R2: A write to the operand register while busy is clear stores the written value and sets busy from the next cycle on.
- R3: A write to the operand register while busy is set has no effect. The operand reads back unchanged and the pending result is not altered.
- R4: While busy is set, the operand register reads back the value that started the computation.
- R5: For an operand n of 2 or more, busy stays set for exactly n cycles. For n of 0 or 1 it stays set for exactly one cycle. When busy clears, the operand register holds the product of the integers from n down to 1, which is 1 for n of 0 or 1.
- R6: The result wraps modulo 2^32. For example, an operand of 13 yields 1932053504.
- R7: If interrupt enable is set in the cycle that busy clears, irq_req is high for exactly the following cycle and irq_cause reads 0x1. In every other cycle irq_req is low and irq_cause is 0.
- R8: A write to the status register sets interrupt enable from data bit 7. Data bit 0 of that write has no effect on busy.
- R9: A write to the liveness register makes it read back as the bitwise complement of the written data.
- R10: After reset, every register reads zero and irq_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_req | output | 1 | One-cycle completion interrupt request |
| irq_cause | output | 4 | Interrupt cause, 0x1 while irq_req is high |

## Verification
Three kinds of internal error reach the ports quickly.
- A wrong loop count or a stuck accumulator shows up as a wrong value at address 1 in the first cycle after busy falls.
- A miscounted loop also moves the fall of status bit 0 away from the expected cycle.
- A write that slips through while busy changes the address 1 read in the very next cycle.

A lost or stretched interrupt shows on irq_req within one cycle of completion. Because of this, the reference model compares the read bus and both interrupt pins on every clock instead of only at the end of each run.

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CAUSE_W   = 4,
  parameter int IRQ_CAUSE = 1,
  parameter int IEN_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_req,
  output logic [CAUSE_W-1:0] irq_cause
);
  localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OPND = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);

  logic [DATA_W-1:0] live_q, opnd_q, acc_q, cnt_q;
  logic              busy_q, ien_q, irq_q;
  logic              last_step;

  assign last_step = busy_q && (cnt_q <= DATA_W'(1));
  assign irq_req   = irq_q;
  assign irq_cause = irq_q ? CAUSE_W'(IRQ_CAUSE) : '0;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_LIVE: bus_rdata = live_q;
      A_OPND: bus_rdata = opnd_q;
      A_STAT: begin
        bus_rdata[0]       = busy_q;
        bus_rdata[IEN_BIT] = ien_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      opnd_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (bus_wr && bus_addr == A_LIVE) live_q <= ~bus_wdata;
      if (bus_wr && bus_addr == A_STAT) ien_q <= bus_wdata[IEN_BIT];
      if (busy_q) begin
        if (last_step) begin
          opnd_q <= acc_q;
          busy_q <= 1'b0;
          irq_q  <= ien_q;
        end else begin
          acc_q <= acc_q * cnt_q;
          cnt_q <= cnt_q - DATA_W'(1);
        end
      end else if (bus_wr && bus_addr == A_OPND) begin
        opnd_q <= bus_wdata;
        cnt_q  <= bus_wdata;
        acc_q  <= DATA_W'(1);
        busy_q <= 1'b1;
      end
    end
  end
endmodule

module fact_engine_chk #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 2,
  parameter int IEN_BIT = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy_q,
  input logic              ien_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] opnd_q,
  input logic [DATA_W-1:0] live_q,
  input logic              irq_req
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && bus_wr && bus_addr == ADDR_W'(1)) |=> (busy_q && opnd_q == $past(bus_wdata)));

  assert_opnd_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q > DATA_W'(1)) |=> ($stable(opnd_q) && busy_q));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($past(ien_q) && $fell(busy_q)));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  assert_ien_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(2)) |=> (ien_q == $past(bus_wdata[IEN_BIT])));

  assert_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> (live_q == ~$past(bus_wdata)));
endmodule

bind fact_engine fact_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IEN_BIT(IEN_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .busy_q(busy_q), .ien_q(ien_q), .cnt_q(cnt_q), .opnd_q(opnd_q), .live_q(live_q),
  .irq_req(irq_req)
);

// File: tb/fact_engine_tb.sv
module fact_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [3:0]  irq_cause;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fact_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req), .irq_cause(irq_cause)
  );

  // behavioural reference model
  logic [31:0] m_live, m_opnd, m_res;
  bit          m_busy, m_ien, m_irq;
  int          m_rem;

  function automatic logic [31:0] fact_of(logic [31:0] n);
    logic [31:0] r = 32'd1;
    for (int i = 2; i <= int'(n); i++) r = r * 32'(i);
    return r;
  endfunction

  always @(posedge clk) begin
    bit fin;
    if (!rst_n) begin
      m_live = '0; m_opnd = '0; m_res = '0;
      m_busy = 0; m_ien = 0; m_irq = 0; m_rem = 0;
    end else begin
      fin = m_busy && m_rem == 1;
      m_irq = fin && m_ien;
      if (bus_wr && bus_addr == 2'd0) m_live = ~bus_wdata;
      if (bus_wr && bus_addr == 2'd2) m_ien = bus_wdata[7];
      if (m_busy) begin
        m_rem--;
        if (fin) begin m_busy = 0; m_opnd = m_res; end
      end else if (bus_wr && bus_addr == 2'd1) begin
        m_opnd = bus_wdata;
        m_busy = 1;
        m_rem  = (bus_wdata <= 32'd1) ? 1 : int'(bus_wdata);
        m_res  = fact_of(bus_wdata);
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [31:0] exp;
    string tag;
    case (bus_addr)
      2'd0: begin exp = m_live; tag = "R9 liveness read"; end
      2'd1: begin exp = m_opnd; tag = m_busy ? "R4 operand read busy" : "R5 result read"; end
      2'd2: begin exp = {24'd0, m_ien, 6'd0, m_busy}; tag = "R8 status read"; end
      default: begin exp = '0; tag = "R1 unmapped read"; end
    endcase
    if (!rst_n) tag = "R10 reset read";
    check(tag, bus_rdata, exp);
    check("R7 irq_req", 32'(irq_req), 32'(m_irq));
    check("R7 irq_cause", 32'(irq_cause), m_irq ? 32'd1 : 32'd0);
  end

  task automatic put(logic [1:0] a, logic [31:0] d);
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic sel(logic [1:0] a);
    @(posedge clk); #2;
    bus_addr = a;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    bus_addr = 2'd2;
    @(negedge clk);
    while (bus_rdata[0] && cyc < 100000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run(logic [31:0] n, logic [31:0] exp, int exp_cyc, string tag);
    int cyc;
    put(2'd1, n);
    #1;
    cyc = 1;
    bus_addr = 2'd2;
    @(negedge clk);
    while (bus_rdata[0] && cyc < 100000) begin
      @(negedge clk);
      cyc++;
    end
    check({tag, " R5 busy cycles"}, 32'(cyc - 1), 32'(exp_cyc));
    sel(2'd1);
    @(negedge clk);
    check({tag, " result"}, bus_rdata, exp);
  endtask

  initial begin
    int cyc;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    sel(2'd0); @(negedge clk); check("R10 live after reset", bus_rdata, '0);
    sel(2'd1); @(negedge clk); check("R10 operand after reset", bus_rdata, '0);
    sel(2'd2); @(negedge clk); check("R10 status after reset", bus_rdata, '0);
    sel(2'd3); @(negedge clk); check("R1 address 3", bus_rdata, '0);

    put(2'd0, 32'h1234_5678);
    bus_addr = 2'd0; @(negedge clk); check("R9 complement", bus_rdata, 32'hEDCB_A987);
    put(2'd0, 32'h0);
    bus_addr = 2'd0; @(negedge clk); check("R9 complement zero", bus_rdata, 32'hFFFF_FFFF);

    put(2'd2, 32'h0000_0081);
    bus_addr = 2'd2; @(negedge clk); check("R8 busy bit not writable", bus_rdata, 32'h80);

    put(2'd1, 32'd5);
    bus_addr = 2'd1; @(negedge clk); check("R4 operand during compute", bus_rdata, 32'd5);
    put(2'd1, 32'd7);
    bus_addr = 2'd1; @(negedge clk); check("R3 write while busy ignored", bus_rdata, 32'd5);
    wait_idle(cyc);
    sel(2'd1); @(negedge clk); check("R3 R2 result of 5", bus_rdata, 32'd120);

    run(32'd0, 32'd1, 1, "R5 n=0");
    run(32'd1, 32'd1, 1, "R5 n=1");
    run(32'd2, 32'd2, 2, "R5 n=2");
    run(32'd10, 32'd3628800, 10, "R5 n=10");

    put(2'd2, 32'h0);
    bus_addr = 2'd2; @(negedge clk); check("R8 enable cleared", bus_rdata, 32'h0);
    run(32'd13, 32'd1932053504, 13, "R6 wrap n=13");
    put(2'd2, 32'h80);
    run(32'd12, 32'd479001600, 12, "R7 enabled n=12");
    run(32'd40, 32'd0, 40, "R6 wrap n=40");

    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule